// File: doc/BRIEF.md
# External Memory Port Bus Controller

This block connects a processor core to an external asynchronous memory port. It drives a 16-bit address bus and a 24-bit data bus. It also drives separate select lines for program memory and data memory, read and write strobes, and a line that picks between the two data spaces, X and Y. Each pad-facing signal group has its own output enable, so the pad ring can float the pins when the port is not owned. The data bus comes in as an output, an output enable and a separate input.

The core starts an access by holding `reqValid` with the space, direction, address and write data. The block takes the request when it is idle and strobes the memory for one cycle or more. It then returns a one-cycle `doneOut` pulse, with read data on `rdData`.

One pin pair is shared, and the `modeStrobe` input picks its use:
- **Mode clear:** the pair is a bus request input and a bus grant output. Another master may take the port, but only at an instruction boundary that the core signals.
- **Mode set:** the pair is a wait input that stretches the access, and a bus strobe that marks every access cycle.

Top module: `ext_port_ctrl`

## Requirements
- R1: While `rstN` is low, every output enable (`addrOe`, `dataOe`, `ctlOe`, `gntStbOe`) is low and `doneOut` is low. In the first cycle after reset is released, `addrOe`, `ctlOe` and `gntStbOe` are high.
- R2: `addrOut` changes only when a new access is accepted. Between accesses, and while the port is released, it keeps the last accessed address.
- R3: `reqSpace` is encoded 0 = program, 1 = X data, 2 = Y data, 3 = Y data. `progSel` is high only during a program access, and `dataSel` only during a data access. During a data access `xySel` is 0 for X and 1 for Y, and it keeps that value through later program accesses and idle cycles.
- R4: `rdStb` and `wrStb` are never high together. `rdStb` marks read access cycles and `wrStb` marks write access cycles. `dataOe` is high only during write access cycles, with the write data on `dataOut`.
- R5: A request that is accepted at a clock edge strobes the memory in the next cycle. `doneOut` rises in the cycle after the last access cycle. For a read, `rdData` then holds the `dataIn` value from the last access cycle.
- R6: With `modeStrobe` set, each access cycle in which `reqWaitIn` is high adds one more access cycle.
- R7: With `modeStrobe` set, `gntStb` is high exactly during access cycles.
- R8: With `modeStrobe` clear, an idle cycle with `reqWaitIn` (bus request) and `instrBoundary` both high releases the port. This takes priority over a waiting core request. In the next cycle all port enables are low and `gntStb` is low. From the cycle after that, `gntStb` is high.
- R9: While grant is high, `addrOe`, `dataOe` and `ctlOe` are low.
- R10: After bus request drops, `gntStb` falls in the next cycle while the port stays floated. The port is driven again one cycle later, and a pending core request is then served.
- R11: Bus request without `instrBoundary`, or any `reqWaitIn` activity with `modeStrobe` set, never releases the port.
- R12: `doneOut` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeStrobe | input | 1 | 0: request/grant use of the shared pair; 1: wait/bus strobe use |
| reqValid | input | 1 | Core access request, held until accepted |
| reqSpace | input | 2 | 0 program, 1 X data, 2 or 3 Y data |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 24 | Write data |
| instrBoundary | input | 1 | Core is at an instruction boundary |
| doneOut | output | 1 | One-cycle access completion pulse |
| rdData | output | 24 | Captured read data |
| addrOut | output | 16 | Address bus |
| addrOe | output | 1 | Address bus enable |
| dataOut | output | 24 | Data bus output value |
| dataOe | output | 1 | Data bus enable |
| dataIn | input | 24 | Data bus input value |
| progSel | output | 1 | Program memory select |
| dataSel | output | 1 | Data memory select |
| xySel | output | 1 | Data space select, 1 = Y |
| rdStb | output | 1 | Read strobe |
| wrStb | output | 1 | Write strobe |
| ctlOe | output | 1 | Enable for selects, X/Y and strobes |
| reqWaitIn | input | 1 | Bus request (mode 0) or wait (mode 1) |
| gntStb | output | 1 | Bus grant (mode 0) or bus strobe (mode 1) |
| gntStbOe | output | 1 | Enable for gntStb |

## Verification
The embedded properties watch several rules on every cycle:
- read and write strobes never overlap, and the two selects never overlap;
- the address register stays still unless a request is loaded;
- grant never coincides with a driven port;
- the bus strobe follows the access cycles in wait mode;
- done is a single pulse that follows an access cycle;
- all enables are off in reset.

Other behaviour needs the bench's scenarios to show it:
- the exact access length under inserted waits and the captured read value;
- the X/Y hold across program accesses;
- the cycle-by-cycle release, grant, drop-grant and re-drive order;
- release taking priority over a waiting request;
- no release without a boundary or in wait mode.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef enum logic [1:0] {
    SPACE_PROG = 2'd0,
    SPACE_X    = 2'd1,
    SPACE_Y    = 2'd2,
    SPACE_Y2   = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    ST_PARK    = 3'd0,
    ST_IDLE    = 3'd1,
    ST_ACCESS  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_GRANTED = 3'd4,
    ST_RECLAIM = 3'd5
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // accept a core request into the datapath registers
    logic captureRd;  // final access cycle: sample read data
    logic inAccess;   // an external access cycle is under way
    logic drivePort;  // the port is owned and driven
  } ctl_strobe_t;

endpackage

// File: rtl/epc_ctrl.sv
module epc_ctrl
  import epc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeStrobe,
  input  logic        reqValid,
  input  logic        instrBoundary,
  input  logic        reqWaitIn,
  output ctl_strobe_t strb,
  output logic        doneOut,
  output logic        grantOut,
  output logic        ctlAlive
);

  state_e stateQ, stateD;
  logic   doneQ;
  logic   arbReq;
  logic   waitReq;
  logic   releaseNow;

  assign arbReq     = !modeStrobe && reqWaitIn;
  assign waitReq    = modeStrobe && reqWaitIn;
  assign releaseNow = arbReq && instrBoundary;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_PARK:    stateD = ST_IDLE;
      ST_IDLE: begin
        if (releaseNow)    stateD = ST_RELEASE;
        else if (reqValid) stateD = ST_ACCESS;
      end
      ST_ACCESS:  if (!waitReq) stateD = ST_IDLE;
      ST_RELEASE: stateD = arbReq ? ST_GRANTED : ST_RECLAIM;
      ST_GRANTED: if (!arbReq) stateD = ST_RECLAIM;
      ST_RECLAIM: stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_PARK;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.captureRd;
    end
  end

  always_comb begin
    strb.loadReq   = (stateQ == ST_IDLE) && !releaseNow && reqValid;
    strb.inAccess  = (stateQ == ST_ACCESS);
    strb.captureRd = (stateQ == ST_ACCESS) && !waitReq;
    strb.drivePort = (stateQ == ST_IDLE) || (stateQ == ST_ACCESS);
  end

  assign doneOut  = doneQ;
  assign grantOut = (stateQ == ST_GRANTED);
  assign ctlAlive = (stateQ != ST_PARK);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);  // R12

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grantOut |-> $past(!modeStrobe && reqWaitIn));  // R8

endmodule

// File: rtl/epc_datapath.sv
module epc_datapath
  import epc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strb,
  input  logic [1:0]        reqSpace,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              progSel,
  output logic              dataSel,
  output logic              xySel,
  output logic              rdStb,
  output logic              wrStb,
  output logic              ctlOe,
  output logic [DATA_W-1:0] rdData
);

  space_e            spaceQ;
  logic              writeQ;
  logic              xyQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              isProg;

  // Request registers: change only when a request is loaded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spaceQ <= SPACE_PROG;
      writeQ <= 1'b0;
      xyQ    <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.loadReq) begin
      spaceQ <= space_e'(reqSpace);
      writeQ <= reqWrite;
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      if (space_e'(reqSpace) != SPACE_PROG) xyQ <= (space_e'(reqSpace) != SPACE_X);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdDataQ <= '0;
    else if (strb.captureRd && !writeQ) rdDataQ <= dataIn;
  end

  assign isProg  = (spaceQ == SPACE_PROG);
  assign progSel = strb.inAccess && isProg;
  assign dataSel = strb.inAccess && !isProg;
  assign xySel   = xyQ;
  assign rdStb   = strb.inAccess && !writeQ;
  assign wrStb   = strb.inAccess && writeQ;
  assign dataOe  = strb.inAccess && writeQ;
  assign dataOut = wdataQ;
  assign addrOut = addrQ;
  assign addrOe  = strb.drivePort;
  assign ctlOe   = strb.drivePort;
  assign rdData  = rdDataQ;

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && wrStb));  // R4

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(progSel && dataSel));  // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadReq |=> $stable(addrOut));  // R2

endmodule

// File: rtl/ext_port_ctrl.sv
module ext_port_ctrl
  import epc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStrobe,
  input  logic              reqValid,
  input  logic [1:0]        reqSpace,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              instrBoundary,
  output logic              doneOut,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [DATA_W-1:0] dataIn,
  output logic              progSel,
  output logic              dataSel,
  output logic              xySel,
  output logic              rdStb,
  output logic              wrStb,
  output logic              ctlOe,
  input  logic              reqWaitIn,
  output logic              gntStb,
  output logic              gntStbOe
);

  ctl_strobe_t strb;
  logic        grantOut;
  logic        ctlAlive;

  epc_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .modeStrobe    (modeStrobe),
    .reqValid      (reqValid),
    .instrBoundary (instrBoundary),
    .reqWaitIn     (reqWaitIn),
    .strb          (strb),
    .doneOut       (doneOut),
    .grantOut      (grantOut),
    .ctlAlive      (ctlAlive)
  );

  epc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqSpace (reqSpace),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .dataIn   (dataIn),
    .addrOut  (addrOut),
    .addrOe   (addrOe),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .progSel  (progSel),
    .dataSel  (dataSel),
    .xySel    (xySel),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .ctlOe    (ctlOe),
    .rdData   (rdData)
  );

  // Shared pin: grant in mode 0, bus strobe in mode 1
  assign gntStb   = modeStrobe ? strb.inAccess : grantOut;
  assign gntStbOe = ctlAlive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_FLOAT: assert (!addrOe && !dataOe && !ctlOe && !gntStbOe && !doneOut);  // R1
    end
  end

  AST_GRANT_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStrobe && gntStb) |-> (!addrOe && !dataOe && !ctlOe));  // R9

  AST_BUS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    modeStrobe |-> (gntStb == (rdStb || wrStb)));  // R7

  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(rdStb || wrStb));  // R5

endmodule

// File: tb/ext_port_ctrl_tb.sv
`timescale 1ns/1ps
module ext_port_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        modeStrobe = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSpace = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [23:0] reqWdata = '0;
  logic        instrBoundary = 1'b0;
  logic [23:0] dataIn = '0;
  logic        reqWaitIn = 1'b0;
  logic        doneOut, addrOe, dataOe, progSel, dataSel, xySel;
  logic        rdStb, wrStb, ctlOe, gntStb, gntStbOe;
  logic [23:0] rdData, dataOut;
  logic [15:0] addrOut;

  int checks = 0;
  int fails = 0;
  logic [15:0] lastAddr = '0;
  logic        expXy = 1'b0;

  always #5 clk = ~clk;

  ext_port_ctrl u_dut (
    .clk(clk), .rstN(rstN), .modeStrobe(modeStrobe), .reqValid(reqValid),
    .reqSpace(reqSpace), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .instrBoundary(instrBoundary), .doneOut(doneOut),
    .rdData(rdData), .addrOut(addrOut), .addrOe(addrOe), .dataOut(dataOut),
    .dataOe(dataOe), .dataIn(dataIn), .progSel(progSel), .dataSel(dataSel),
    .xySel(xySel), .rdStb(rdStb), .wrStb(wrStb), .ctlOe(ctlOe),
    .reqWaitIn(reqWaitIn), .gntStb(gntStb), .gntStbOe(gntStbOe)
  );

  function automatic logic expIsData(input logic [1:0] sp);
    return sp != 2'd0;
  endfunction

  function automatic logic expIsY(input logic [1:0] sp);
    return sp >= 2'd2;
  endfunction

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Called just after a negedge with the block idle; returns just after a negedge
  task automatic doAccess(input logic [1:0] sp, input logic wr, input logic [15:0] a,
                          input logic [23:0] wd, input int waits, input logic [23:0] rv);
    reqValid = 1'b1; reqSpace = sp; reqWrite = wr; reqAddr = a; reqWdata = wd; dataIn = rv;
    @(posedge clk);
    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      if (i == 0) begin reqValid = 1'b0; reqAddr = ~a; reqWdata = ~wd; end
      chkEq("R3", progSel, !expIsData(sp));
      chkEq("R3", dataSel, expIsData(sp));
      if (expIsData(sp)) chkEq("R3", xySel, expIsY(sp));
      else chkEq("R3", xySel, expXy);
      chkEq("R4", rdStb, !wr);
      chkEq("R4", wrStb, wr);
      chkEq("R4", dataOe, wr);
      if (wr) chkEq("R4", dataOut, wd);
      chkEq("R2", addrOut, a);
      chkEq(i > 0 ? "R6" : "R5", doneOut, 1'b0);
      if (modeStrobe) chkEq("R7", gntStb, 1'b1);
      reqWaitIn = modeStrobe && (i < waits);
      dataIn = rv ^ ((i < waits) ? 24'hFFFFFF : 24'h0);
      dataIn = (i < waits) ? ~rv : rv;
      @(posedge clk);
    end
    @(negedge clk);
    reqWaitIn = 1'b0;
    chkEq(waits > 0 ? "R6" : "R5", doneOut, 1'b1);
    if (!wr) chkEq("R5", rdData, rv);
    chkEq("R4", rdStb | wrStb, 1'b0);
    chkEq("R3", progSel | dataSel, 1'b0);
    if (modeStrobe) chkEq("R7", gntStb, 1'b0);
    chkEq("R2", addrOut, a);
    lastAddr = a;
    if (expIsData(sp)) expXy = expIsY(sp);
    @(posedge clk);
    @(negedge clk);
    chkEq("R12", doneOut, 1'b0);
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      instrBoundary = 1'($urandom_range(0, 1));
      reqWaitIn = modeStrobe ? 1'($urandom_range(0, 1)) : 1'b0;
      @(posedge clk);
      @(negedge clk);
      chkEq("R11", addrOe & ctlOe, 1'b1);
      chkEq("R2", addrOut, lastAddr);
      chkEq("R3", xySel, expXy);
      chkEq("R4", rdStb | wrStb | dataOe, 1'b0);
    end
    instrBoundary = 1'b0;
    reqWaitIn = 1'b0;
  endtask

  // Mode 0: request, release, grant, drop request, reclaim
  task automatic doRelease(input logic pending);
    reqWaitIn = 1'b1; instrBoundary = 1'b1;
    if (pending) begin reqValid = 1'b1; reqSpace = 2'd1; reqWrite = 1'b0; reqAddr = 16'hBEEF; end
    @(posedge clk);
    @(negedge clk);
    instrBoundary = 1'b0;
    chkEq("R8", {addrOe, dataOe, ctlOe}, 3'b000);
    chkEq("R8", gntStb, 1'b0);
    chkEq("R8", gntStbOe, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chkEq("R8", gntStb, 1'b1);
      chkEq("R9", {addrOe, dataOe, ctlOe}, 3'b000);
      chkEq("R2", addrOut, lastAddr);
    end
    reqWaitIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chkEq("R10", gntStb, 1'b0);
    chkEq("R10", addrOe | ctlOe, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chkEq("R10", addrOe & ctlOe, 1'b1);
    chkEq("R10", rdStb | wrStb, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    #2 rstN = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R1", {addrOe, dataOe, ctlOe, gntStbOe, doneOut}, 5'b0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chkEq("R1", {addrOe, ctlOe, gntStbOe}, 3'b111);
    chkEq("R1", gntStb, 1'b0);

    // Directed: mode 0 accesses, all spaces
    doAccess(2'd1, 1'b1, 16'h1234, 24'hA5A5A5, 0, 24'h0);
    doAccess(2'd0, 1'b0, 16'h4321, 24'h0, 0, 24'h5A5A5A);
    chkEq("R3", xySel, 1'b0);
    doAccess(2'd2, 1'b0, 16'hFFFF, 24'h0, 0, 24'hFFFFFF);
    doAccess(2'd0, 1'b1, 16'h0000, 24'h123456, 0, 24'h0);
    chkEq("R3", xySel, 1'b1);

    // Request without boundary: no release
    reqWaitIn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chkEq("R11", addrOe & ctlOe, 1'b1);
      chkEq("R11", gntStb, 1'b0);
    end
    doRelease(1'b0);
    // Release wins over a waiting request, served after reclaim
    doRelease(1'b1);
    doAccess(2'd1, 1'b0, 16'hBEEF, 24'h0, 0, 24'h00C0DE);

    // Mode 1: wait stretch, bus strobe, no release
    modeStrobe = 1'b1;
    reqWaitIn = 1'b1; instrBoundary = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chkEq("R11", addrOe & ctlOe, 1'b1);
      chkEq("R7", gntStb, 1'b0);
    end
    reqWaitIn = 1'b0; instrBoundary = 1'b0;
    doAccess(2'd3, 1'b0, 16'h0F0F, 24'h0, 3, 24'h777777);
    doAccess(2'd0, 1'b1, 16'hF0F0, 24'h888888, 2, 24'h0);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [1:0] sp;
      logic wr;
      if (it % 60 == 0) modeStrobe = ~modeStrobe;
      sp = 2'($urandom_range(0, 3));
      wr = 1'($urandom_range(0, 1));
      doAccess(sp, wr, 16'($urandom), 24'($urandom), modeStrobe ? $urandom_range(0, 3) : 0,
               24'($urandom));
      idleCycles($urandom_range(0, 2));
      if (!modeStrobe && (it % 37 == 5)) doRelease(1'($urandom_range(0, 1)));
      if (reqValid) doAccess(reqSpace, reqWrite, reqAddr, reqWdata, 0, 24'h13579B);
    end
    finishRun();
  end

endmodule